// File: doc/BRIEF.md
# Seven-Room Maze Game Controller

This block is the control core of a small maze game. A player moves between seven rooms with four direction pins. A room state machine holds the player's location in one-hot form, and that state is also the room output. When the player stands in the sword room, the room machine raises an internal flag. A second, two-state machine uses that flag to record that the sword has been picked up, and the sword stays held until reset. The dragon room is a one-cycle stop. On the next clock edge the player goes to the victory room if the sword is held, or to the grave room if it is not. Both of those rooms hold the player until reset.

All pins are plain control and status levels. There is no data stream, so no valid/ready handshake is used. Inputs are sampled on every rising clock edge. All state changes happen on that edge, and reset is synchronous and active-high.

Top module: `maze_game`

## Requirements
- R1: After the first reset edge, exactly one bit of `room_oh` is high on every cycle. The bit meanings are: bit 0 cave, bit 1 tunnel, bit 2 river, bit 3 sword room, bit 4 dragon room, bit 5 victory room, bit 6 grave room.
- R2: A clock edge with `rst` high puts the player in the cave (`room_oh` = 7'b0000001) and clears `sword_held`, whatever the other inputs are. `won` and `dead` are then low.
- R3: The fixed exits are:
  - cave, east → tunnel
  - tunnel, west → cave
  - tunnel, south → river
  - river, east → dragon room
  - river, west → sword room
  - sword room, east → river
- R4: If no direction is asserted, or the selected direction has no exit from the current room, the player stays in the same room on that edge.
- R5: If several direction pins are high together, only one is honoured, in this priority: north, then south, then east, then west. The lower-priority pins are ignored, even when the honoured direction has no exit.
- R6: `sword_held` goes high on the clock edge that ends a cycle spent in the sword room.
- R7: Once high, `sword_held` stays high until a reset edge, whatever the player does next.
- R8: From the dragon room, the next edge moves the player to the victory room if `sword_held` is high, or to the grave room if it is low. The direction inputs have no effect on this move.
- R9: The victory and grave rooms keep the player until reset. `won` is high only in the victory room, and `dead` is high only in the grave room.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go_n | input | 1 | Move north request |
| go_s | input | 1 | Move south request |
| go_e | input | 1 | Move east request |
| go_w | input | 1 | Move west request |
| room_oh | output | 7 | One-hot current room (bit map in R1) |
| sword_held | output | 1 | Player holds the sword |
| won | output | 1 | Player is in the victory room |
| dead | output | 1 | Player is in the grave room |

## Verification
The room state and the room output are the same flip-flops, so a wrong transition shows on `room_oh` right after the faulty edge. A corrupted encoding with zero or two hot bits also shows there right away.

A sword flag that fails to set or fails to hold shows on `sword_held` one edge later. It shows again as a wrong `won`/`dead` result one edge after the player enters the dragon room.

The sequences cover:
- every exit
- dead-end directions in several rooms
- several directions at once, including a case where the winning direction has no exit
- both dragon outcomes
- reset from the absorbing rooms

// File: rtl/maze_pkg.sv
package maze_pkg;
  localparam int ROOMS = 7;
  localparam int DIRS  = 4;
  localparam int RW    = $clog2(ROOMS);

  // room indices: bit positions of the one-hot state and of the output
  localparam int RM_CAVE    = 0;
  localparam int RM_TUNNEL  = 1;
  localparam int RM_RIVER   = 2;
  localparam int RM_SWORD   = 3;
  localparam int RM_DRAGON  = 4;
  localparam int RM_VICTORY = 5;
  localparam int RM_GRAVE   = 6;

  // direction indices; a lower index has higher priority
  localparam int DR_N = 0;
  localparam int DR_S = 1;
  localparam int DR_E = 2;
  localparam int DR_W = 3;

  typedef logic [ROOMS-1:0] room_t;
  typedef logic [DIRS-1:0]  dir_t;

  typedef enum logic { SW_NONE = 1'b0, SW_HELD = 1'b1 } sword_st_t;

  // exit table: returns the destination index, or the room itself when the
  // granted direction has no exit from it
  function automatic int exit_dest(int rm, dir_t g, logic held);
    int d;
    d = rm;
    case (rm)
      RM_CAVE:    if (g[DR_E]) d = RM_TUNNEL;
      RM_TUNNEL: begin
        if (g[DR_W]) d = RM_CAVE;
        if (g[DR_S]) d = RM_RIVER;
      end
      RM_RIVER: begin
        if (g[DR_W]) d = RM_SWORD;
        if (g[DR_E]) d = RM_DRAGON;
      end
      RM_SWORD:   if (g[DR_E]) d = RM_RIVER;
      RM_DRAGON:  d = held ? RM_VICTORY : RM_GRAVE;
      default:    d = rm;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/move_pick.sv
module move_pick
  import maze_pkg::*;
#(
  parameter int N = DIRS
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pri
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
    end
  endgenerate

  // R5: at most one direction is passed on, and only one that was requested
  always_comb begin
    p_grant_onehot_r5: assert ($onehot0(grant));
    p_grant_subset_r5: assert ((grant & ~req) == '0);
  end
endmodule

// File: rtl/room_fsm.sv
module room_fsm
  import maze_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  dir_t  grant,
  input  logic  held,
  output room_t room,
  output logic  at_sword
);
  room_t room_q;
  room_t room_d;

  always_comb begin
    room_d = '0;
    for (int i = 0; i < ROOMS; i++) begin
      if (room_q[i]) room_d[exit_dest(i, grant, held)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) room_q <= room_t'(1) << RM_CAVE;
    else     room_q <= room_d;
  end

  assign room     = room_q;
  assign at_sword = room_q[RM_SWORD];

  p_room_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(room_q) == 1);

  p_reset_cave_r2: assert property (@(posedge clk)
    rst |=> room_q == (room_t'(1) << RM_CAVE));

  p_dead_end_stay_r4: assert property (@(posedge clk) disable iff (rst)
    (room_q[RM_CAVE] && grant == dir_t'(1 << DR_N)) |=> room_q[RM_CAVE]);

  p_dragon_win_r8: assert property (@(posedge clk) disable iff (rst)
    (room_q[RM_DRAGON] && held) |=> room_q[RM_VICTORY]);

  p_dragon_lose_r8: assert property (@(posedge clk) disable iff (rst)
    (room_q[RM_DRAGON] && !held) |=> room_q[RM_GRAVE]);

  p_absorb_r9: assert property (@(posedge clk) disable iff (rst)
    (room_q[RM_VICTORY] || room_q[RM_GRAVE]) |=> $stable(room_q));
endmodule

// File: rtl/sword_fsm.sv
module sword_fsm
  import maze_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic at_sword,
  output logic held
);
  sword_st_t st_q;
  sword_st_t st_d;

  always_comb begin
    st_d = st_q;
    if (st_q == SW_NONE && at_sword) st_d = SW_HELD;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SW_NONE;
    else     st_q <= st_d;
  end

  assign held = (st_q == SW_HELD);

  p_sword_clear_r2: assert property (@(posedge clk) rst |=> !held);

  p_sword_pick_r6: assert property (@(posedge clk) disable iff (rst)
    at_sword |=> held);

  p_sword_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    held |=> held);
endmodule

// File: rtl/maze_game.sv
module maze_game
  import maze_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go_n,
  input  logic             go_s,
  input  logic             go_e,
  input  logic             go_w,
  output logic [ROOMS-1:0] room_oh,
  output logic             sword_held,
  output logic             won,
  output logic             dead
);
  dir_t  req;
  dir_t  grant;
  room_t room;
  logic  at_sword;
  logic  held;

  always_comb begin
    req       = '0;
    req[DR_N] = go_n;
    req[DR_S] = go_s;
    req[DR_E] = go_e;
    req[DR_W] = go_w;
  end

  move_pick #(.N(DIRS)) u_pick (
    .req   (req),
    .grant (grant)
  );

  room_fsm u_room (
    .clk      (clk),
    .rst      (rst),
    .grant    (grant),
    .held     (held),
    .room     (room),
    .at_sword (at_sword)
  );

  sword_fsm u_sword (
    .clk      (clk),
    .rst      (rst),
    .at_sword (at_sword),
    .held     (held)
  );

  assign room_oh    = room;
  assign sword_held = held;
  assign won        = room[RM_VICTORY];
  assign dead       = room[RM_GRAVE];

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(won && dead));
endmodule

// File: tb/maze_game_tb.sv
`timescale 1ns/1ps
module maze_game_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       go_n = 1'b0, go_s = 1'b0, go_e = 1'b0, go_w = 1'b0;
  logic [6:0] room_oh;
  logic       sword_held, won, dead;

  maze_game u_dut (
    .clk(clk), .rst(rst), .go_n(go_n), .go_s(go_s), .go_e(go_e), .go_w(go_w),
    .room_oh(room_oh), .sword_held(sword_held), .won(won), .dead(dead)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [6:0] room;
    logic       v;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   errors  = 0;
  int   m_room  = 0;
  logic m_v     = 1'b0;
  bit   done    = 0;

  // reference map from the requirements
  // rooms: 0 cave, 1 tunnel, 2 river, 3 sword, 4 dragon, 5 victory, 6 grave
  function automatic int ref_next(int r, logic [3:0] nsew, logic v);
    int   nx;
    logic n, s, e, w;
    nx = r;
    n = nsew[3];
    s = nsew[2] & ~n;
    e = nsew[1] & ~n & ~nsew[2];
    w = nsew[0] & ~n & ~nsew[2] & ~nsew[1];
    if      (r == 0 && e) nx = 1;
    else if (r == 1 && s) nx = 2;
    else if (r == 1 && w) nx = 0;
    else if (r == 2 && e) nx = 4;
    else if (r == 2 && w) nx = 3;
    else if (r == 3 && e) nx = 2;
    else if (r == 4)      nx = v ? 5 : 6;
    return nx;
  endfunction

  // driver: applies one cycle of input and queues the expected result
  task automatic step(input logic r, input logic [3:0] nsew, input string tag);
    exp_t x;
    int   nr;
    logic nv;
    @(negedge clk);
    rst  = r;
    go_n = nsew[3];
    go_s = nsew[2];
    go_e = nsew[1];
    go_w = nsew[0];
    if (r) begin
      nr = 0;
      nv = 1'b0;
    end else begin
      nr = ref_next(m_room, nsew, m_v);
      nv = m_v | (m_room == 3);
    end
    x.room = 7'b1 << nr;
    x.v    = nv;
    x.tag  = tag;
    exp_q.push_back(x);
    m_room = nr;
    m_v    = nv;
  endtask

  // monitor: compares just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t x;
        x = exp_q.pop_front();
        vectors++;
        if (room_oh !== x.room || sword_held !== x.v ||
            won !== x.room[5] || dead !== x.room[6] ||
            $countones(room_oh) != 1) begin
          errors++;
          $display("FAIL %s: room=%b v=%b won=%b dead=%b expected room=%b v=%b won=%b dead=%b",
                   x.tag, room_oh, sword_held, won, dead,
                   x.room, x.v, x.room[5], x.room[6]);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    step(1, 4'b0000, "R2 reset");
    step(1, 4'b0010, "R2 reset ignores moves");
    step(0, 4'b0000, "R4 idle in cave");
    step(0, 4'b1000, "R4 cave north no exit");
    step(0, 4'b0001, "R4 cave west no exit");
    step(0, 4'b0010, "R3 cave east to tunnel");
    step(0, 4'b1000, "R4 tunnel north no exit");
    step(0, 4'b0001, "R3 tunnel west to cave");
    step(0, 4'b0010, "R3 cave east to tunnel");
    step(0, 4'b1001, "R5 north wins over west, stays");
    step(0, 4'b0101, "R5 south wins over west");
    step(0, 4'b0001, "R3 river west to sword room");
    step(0, 4'b1000, "R6 sword picked up, R4 stay");
    step(0, 4'b0010, "R3 sword room east to river, R7 held");
    step(0, 4'b0000, "R7 held while idle");
    step(0, 4'b0011, "R5 east wins over west");
    step(0, 4'b0001, "R8 dragon with sword to victory");
    step(0, 4'b1111, "R9 victory absorbing");
    step(0, 4'b0010, "R9 victory absorbing");
    step(1, 4'b0000, "R2 reset from victory");
    step(0, 4'b0010, "R3 cave east to tunnel");
    step(0, 4'b0100, "R3 tunnel south to river");
    step(0, 4'b0010, "R3 river east to dragon");
    step(0, 4'b0010, "R8 dragon without sword to grave");
    step(0, 4'b0001, "R9 grave absorbing");
    step(0, 4'b0000, "R1 grave holds single room");
    step(1, 4'b0000, "R2 reset from grave");
    step(0, 4'b0000, "R1 cave after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule